// File: doc/BRIEF.md
# Hierarchical DMA Request Sequencer

This block sequences the beats of one DMA channel through three nested levels: a transaction is a number of blocks, and a block is a number of fragments. A fragment is a number of beats. Software programs the fragment length, the fragments per block, the blocks per transaction, the source and destination base addresses and a per-beat address step. It then pulses a start input. A peripheral raises a request, and the sequencer moves beats until it reaches the boundary that the request mode sets. It acknowledges that request and waits for the next one. When the last beat of the transaction has moved, it goes idle.

Each beat drives a read strobe and a write strobe toward a simple memory-side port, together with linear source and destination addresses. Completion events at each level, and rejected configurations, set sticky status bits. A write-one-to-clear input clears those bits. The interrupt-type field of the control word selects which status bits drive the single interrupt line.

Top module: `dma_seq_top`

## Requirements
- R1: After reset, status_o is 0, and irq_o, ack_o, busy_o, rd_o and wr_o are all low.
- R2: The control word carries the request mode in flags_i[17:16] (0 fragment, 1 block, 2 transaction, 3 link-list) and the interrupt type in flags_i[3:0]. The word is captured only on an accepted start_i.
- R3: A start_i with a zero fragment length, zero fragments per block, zero blocks per transaction or an interrupt type above 8 sets status bit 4 one cycle later. It leaves busy_o low and no beat follows.
- R4: In fragment mode, a request moves exactly frag_len_i beats, one per cycle, with rd_o and wr_o both high.
- R5: In block mode, a request moves exactly frag_len_i*frags_per_blk_i beats.
- R6: In transaction and link-list modes, one request moves every beat of the transaction, and the block then goes idle.
- R7: Beat n of a transaction (counting from 0, across requests) reads src_base + n*step and writes dst_base + n*step.
- R8: ack_o is a single-cycle pulse in the cycle after the last beat of each request. busy_o drops in that same cycle only after the final beat of the transaction.
- R9: Status bits are sticky. Bit 0 marks a fragment done, bit 1 a block done, bit 2 a transaction done, bit 3 a transaction done in link-list mode and bit 4 a configuration error.
- R10: A 1 on bit i of irq_clr_i clears status bit i. Other bits are unaffected.
- R11: irq_o is the OR of the status bits that the interrupt type enables. The types map as follows: 0 none, 1 {0}, 2 {1}, 3 {0,1}, 4 {2}, 5 {0,2}, 6 {1,2}, 7 {3}, 8 {4}. Any other type enables nothing.
- R12: req_i during beat movement and start_i while busy_o is high are ignored. Beat counts and addresses do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load configuration and arm the channel |
| flags_i | input | 32 | Mode in [17:16], interrupt type in [3:0] |
| frag_len_i | input | CNT_W | Beats per fragment |
| frags_per_blk_i | input | CNT_W | Fragments per block |
| blks_per_trn_i | input | CNT_W | Blocks per transaction |
| src_base_i | input | AW | Source start address |
| dst_base_i | input | AW | Destination start address |
| step_i | input | AW | Address increment per beat |
| req_i | input | 1 | Peripheral request |
| ack_o | output | 1 | Request serviced pulse |
| busy_o | output | 1 | Transaction armed or in progress |
| rd_o | output | 1 | Read beat strobe |
| rd_addr_o | output | AW | Read address |
| wr_o | output | 1 | Write beat strobe |
| wr_addr_o | output | AW | Write address |
| irq_clr_i | input | 5 | Write-one-to-clear for status bits |
| status_o | output | 5 | Sticky status bits |
| irq_o | output | 1 | Combined interrupt |

## Verification
Random transactions vary all four modes, all interrupt types and counts of 1 to 3 at each level. Beats per request separate the fragment, block and transaction boundaries, and a count of 1 at some level exposes counter wrap mistakes. Addresses checked across several requests show whether the address state persists between requests. Directed cases inject a request and a start during movement, and try each invalid count and interrupt type. Partial clears check that each status bit is cleared on its own.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int ST_W     = 5;
  localparam int ST_FRAG  = 0;
  localparam int ST_BLK   = 1;
  localparam int ST_TRN   = 2;
  localparam int ST_LIST  = 3;
  localparam int ST_CFG   = 4;
  localparam int MODE_LSB = 16;
  localparam int ITYPE_W  = 4;
  localparam int LEVELS   = 3;

  typedef enum logic [1:0] {
    MODE_FRAG = 2'd0,
    MODE_BLK  = 2'd1,
    MODE_TRN  = 2'd2,
    MODE_LIST = 2'd3
  } req_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_MOVE = 2'd2
  } seq_state_e;

  function automatic logic [ST_W-1:0] itype_mask(input logic [ITYPE_W-1:0] it);
    logic [ST_W-1:0] m;
    m = '0;
    case (it)
      4'd1: m[ST_FRAG] = 1'b1;
      4'd2: m[ST_BLK]  = 1'b1;
      4'd3: begin m[ST_FRAG] = 1'b1; m[ST_BLK] = 1'b1; end
      4'd4: m[ST_TRN]  = 1'b1;
      4'd5: begin m[ST_FRAG] = 1'b1; m[ST_TRN] = 1'b1; end
      4'd6: begin m[ST_BLK]  = 1'b1; m[ST_TRN] = 1'b1; end
      4'd7: m[ST_LIST] = 1'b1;
      4'd8: m[ST_CFG]  = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
  import dma_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 accept_i,
  input  logic [31:0]          flags_i,
  input  logic [CNT_W-1:0]     frag_len_i,
  input  logic [CNT_W-1:0]     frags_per_blk_i,
  input  logic [CNT_W-1:0]     blks_per_trn_i,
  input  logic [AW-1:0]        step_i,
  output logic                 load_o,
  output logic                 err_o,
  output req_mode_e            mode_o,
  output logic [ST_W-1:0]      mask_o,
  output logic [CNT_W-1:0]     len_o,
  output logic [CNT_W-1:0]     fpb_o,
  output logic [CNT_W-1:0]     bpt_o,
  output logic [AW-1:0]        step_o
);
  logic [ITYPE_W-1:0] itype;
  logic               cfg_ok;
  logic               take;

  assign itype  = flags_i[ITYPE_W-1:0];
  assign cfg_ok = (frag_len_i != '0) && (frags_per_blk_i != '0) &&
                  (blks_per_trn_i != '0) && (itype <= ITYPE_W'(8));
  assign take   = start_i && accept_i;
  assign load_o = take && cfg_ok;
  assign err_o  = take && !cfg_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_FRAG;
      mask_o <= '0;
      len_o  <= '0;
      fpb_o  <= '0;
      bpt_o  <= '0;
      step_o <= '0;
    end else if (load_o) begin
      mode_o <= req_mode_e'(flags_i[MODE_LSB+1:MODE_LSB]);
      mask_o <= itype_mask(itype);
      len_o  <= frag_len_i;
      fpb_o  <= frags_per_blk_i;
      bpt_o  <= blks_per_trn_i;
      step_o <= step_i;
    end else if (err_o) begin
      // a rejected config keeps only its interrupt selection so a cfg error can signal
      mask_o <= itype_mask(itype);
    end
  end
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic         last_o,
  output logic [W-1:0] val_o
);
  assign last_o = (val_o == lim_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_o <= '0;
    else if (clr_i)  val_o <= '0;
    else if (inc_i)  val_o <= last_o ? '0 : val_o + W'(1);
  end

  assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i != '0 && !clr_i) |-> (val_o < lim_i));
endmodule

// File: rtl/dma_seq_irq.sv
module dma_seq_irq
  import dma_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] clr_i,
  input  logic [ST_W-1:0] mask_i,
  output logic [ST_W-1:0] status_o,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= set_i | (status_o & ~clr_i);
  end

  assign irq_o = |(status_o & mask_i);

  assert_clear_works_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[ST_CFG] && !set_i[ST_CFG]) |=> !status_o[ST_CFG]);
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      flags_i,
  input  logic [CNT_W-1:0] frag_len_i,
  input  logic [CNT_W-1:0] frags_per_blk_i,
  input  logic [CNT_W-1:0] blks_per_trn_i,
  input  logic [AW-1:0]    src_base_i,
  input  logic [AW-1:0]    dst_base_i,
  input  logic [AW-1:0]    step_i,
  input  logic             req_i,
  output logic             ack_o,
  output logic             busy_o,
  output logic             rd_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wr_o,
  output logic [AW-1:0]    wr_addr_o,
  input  logic [4:0]       irq_clr_i,
  output logic [4:0]       status_o,
  output logic             irq_o
);
  seq_state_e state_q, state_d;
  req_mode_e  mode_q;
  logic [ST_W-1:0]  mask_q;
  logic [CNT_W-1:0] len_q, fpb_q, bpt_q;
  logic [AW-1:0]    step_q;
  logic             load, cfg_err;
  logic             beat;
  logic             frag_end, blk_end, trn_end, unit_end;
  logic [ST_W-1:0]  set_ev;
  logic [CNT_W-1:0] lim  [LEVELS];
  logic [CNT_W-1:0] cval [LEVELS];
  logic [LEVELS-1:0] inc, last;
  logic [AW-1:0]    src_q, dst_q;
  logic             ack_q;

  dma_seq_cfg #(.AW(AW), .CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .start_i,
    .accept_i        (state_q == S_IDLE),
    .flags_i, .frag_len_i, .frags_per_blk_i, .blks_per_trn_i, .step_i,
    .load_o          (load),
    .err_o           (cfg_err),
    .mode_o          (mode_q),
    .mask_o          (mask_q),
    .len_o           (len_q),
    .fpb_o           (fpb_q),
    .bpt_o           (bpt_q),
    .step_o          (step_q)
  );

  assign beat   = (state_q == S_MOVE);
  assign lim[0] = len_q;
  assign lim[1] = fpb_q;
  assign lim[2] = bpt_q;

  // level i advances when every level below it wraps
  genvar g;
  generate
    for (g = 0; g < LEVELS; g++) begin : g_lvl
      if (g == 0) begin : g_base
        assign inc[g] = beat;
      end else begin : g_chain
        assign inc[g] = inc[g-1] & last[g-1];
      end
      dma_seq_cnt #(.W(CNT_W)) u_cnt (
        .clk_i, .rst_ni,
        .clr_i  (load),
        .inc_i  (inc[g]),
        .lim_i  (lim[g]),
        .last_o (last[g]),
        .val_o  (cval[g])
      );
    end
  endgenerate

  assign frag_end = inc[0] & last[0];
  assign blk_end  = inc[1] & last[1];
  assign trn_end  = inc[2] & last[2];

  always_comb begin
    case (mode_q)
      MODE_FRAG: unit_end = frag_end;
      MODE_BLK:  unit_end = blk_end;
      default:   unit_end = trn_end;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (load)  state_d = S_WAIT;
      S_WAIT: if (req_i) state_d = S_MOVE;
      S_MOVE: begin
        if (trn_end)       state_d = S_IDLE;
        else if (unit_end) state_d = S_WAIT;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= unit_end;
      if (load) begin
        src_q <= src_base_i;
        dst_q <= dst_base_i;
      end else if (beat) begin
        src_q <= src_q + step_q;
        dst_q <= dst_q + step_q;
      end
    end
  end

  assign set_ev[ST_FRAG] = frag_end;
  assign set_ev[ST_BLK]  = blk_end;
  assign set_ev[ST_TRN]  = trn_end;
  assign set_ev[ST_LIST] = trn_end && (mode_q == MODE_LIST);
  assign set_ev[ST_CFG]  = cfg_err;

  dma_seq_irq u_irq (
    .clk_i, .rst_ni,
    .set_i    (set_ev),
    .clr_i    (irq_clr_i),
    .mask_i   (mask_q),
    .status_o (status_o),
    .irq_o    (irq_o)
  );

  assign ack_o     = ack_q;
  assign busy_o    = (state_q != S_IDLE);
  assign rd_o      = beat;
  assign wr_o      = beat;
  assign rd_addr_o = src_q;
  assign wr_addr_o = dst_q;

  assert_ack_after_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(rd_o));
  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && $past(rd_o)) |-> (rd_addr_o == $past(rd_addr_o) + step_q));
  assert_trn_goes_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_TRN]) |-> !busy_o);
  assert_cfg_err_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[ST_CFG]) |-> ($past(start_i) && !busy_o));
  assert_no_start_when_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !$rose(status_o[ST_CFG]));
endmodule

// File: tb/dma_seq_top_tb_top.sv
`timescale 1ns/1ps
module dma_seq_top_tb_top;
  localparam int AW = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   flags_i = '0;
  logic [CW-1:0] frag_len_i = '0, fpb_i = '0, bpt_i = '0;
  logic [AW-1:0] src_i = '0, dst_i = '0, step_i = '0;
  logic          req_i = 1'b0;
  logic          ack_o, busy_o, rd_o, wr_o, irq_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [4:0]    clr_i = '0;
  logic [4:0]    status_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [AW-1:0] exp_src, exp_dst, cur_step;

  always #4 clk = ~clk;

  dma_seq_top #(.AW(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .flags_i,
    .frag_len_i, .frags_per_blk_i(fpb_i), .blks_per_trn_i(bpt_i),
    .src_base_i(src_i), .dst_base_i(dst_i), .step_i,
    .req_i, .ack_o, .busy_o, .rd_o, .rd_addr_o, .wr_o, .wr_addr_o,
    .irq_clr_i(clr_i), .status_o, .irq_o);

  function automatic logic [4:0] ref_mask(input int it);
    case (it)
      1: return 5'b00001;
      2: return 5'b00010;
      3: return 5'b00011;
      4: return 5'b00100;
      5: return 5'b00101;
      6: return 5'b00110;
      7: return 5'b01000;
      8: return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  function automatic int unit_beats(input int mode, input int l, input int f, input int b);
    if (mode == 0) return l;
    if (mode == 1) return l * f;
    return l * f * b;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int mode, input int it, input int l, input int f, input int b,
                          input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [AW-1:0] st);
    @(negedge clk);
    flags_i = (32'(mode) << 16) | 32'(it);
    frag_len_i = CW'(l); fpb_i = CW'(f); bpt_i = CW'(b);
    src_i = s; dst_i = d; step_i = st;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_src = s; exp_dst = d; cur_step = st;
  endtask

  // issues one request and checks beats, addresses and ack; inject pokes req/start mid-move (R12)
  task automatic run_req(input int exp_beats, input bit last_req, input bit inject, input string tag);
    int beats = 0;
    int guard = 0;
    bit got_ack = 1'b0;
    @(negedge clk);
    req_i = 1'b1;
    @(negedge clk);
    while (!got_ack && guard < 2000) begin
      req_i = 1'b0;
      start_i = 1'b0;
      if (rd_o) begin
        chk(rd_addr_o == exp_src && wr_addr_o == exp_dst && wr_o, "R7", rd_addr_o, exp_src);
        exp_src += cur_step;
        exp_dst += cur_step;
        beats++;
        if (inject && beats == 2) begin
          req_i = 1'b1; start_i = 1'b1; src_i = 32'hDEAD_0000;
        end
      end
      if (ack_o) got_ack = 1'b1;
      else begin @(negedge clk); guard++; end
    end
    chk(got_ack, "R8", got_ack, 1);
    chk(beats == exp_beats, tag, beats, exp_beats);
    chk(busy_o == !last_req, "R8", busy_o, !last_req);
    @(negedge clk);
    chk(!ack_o, "R8", ack_o, 0);
  endtask

  task automatic run_trn(input int mode, input int it, input int l, input int f, input int b);
    int per, total, nreq;
    string tag;
    logic [4:0] es, cm;
    do_start(mode, it, l, f, b, $urandom & 32'hFFFF_FFF0, $urandom & 32'hFFFF_FFF0,
             32'($urandom_range(1, 16)));
    chk(busy_o, "R2", busy_o, 1);
    per = unit_beats(mode, l, f, b);
    total = l * f * b;
    nreq = total / per;
    tag = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
    for (int i = 0; i < nreq; i++) run_req(per, i == nreq - 1, 1'b0, tag);
    es = {1'b0, mode == 3, 3'b111};
    chk(status_o == es, "R9", status_o, es);
    chk(irq_o == |(es & ref_mask(it)), "R11", irq_o, |(es & ref_mask(it)));
    cm = 5'($urandom);
    @(negedge clk); clr_i = cm;
    @(negedge clk); clr_i = '0;
    chk(status_o == (es & ~cm), "R10", status_o, es & ~cm);
    @(negedge clk); clr_i = 5'h1F;
    @(negedge clk); clr_i = '0;
    chk(status_o == 5'b0, "R10", status_o, 0);
  endtask

  task automatic bad_start(input int it, input int l, input int f, input int b);
    int beats = 0;
    do_start(0, it, l, f, b, 32'h100, 32'h200, 32'd4);
    chk(status_o[4] && !busy_o, "R3", status_o, 5'b10000);
    chk(irq_o == (it == 8), "R11", irq_o, it == 8);
    req_i = 1'b1;
    repeat (4) begin @(negedge clk); if (rd_o) beats++; end
    req_i = 1'b0;
    chk(beats == 0, "R3", beats, 0);
    clr_i = 5'h10;
    @(negedge clk); clr_i = '0;
    chk(status_o == 5'b0, "R10", status_o, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(status_o == 0 && !irq_o && !ack_o && !busy_o && !rd_o && !wr_o, "R1", status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 0 && !irq_o && !busy_o && !rd_o, "R1", status_o, 0);

    // R3: each invalid field
    bad_start(8, 0, 2, 2);
    bad_start(1, 2, 0, 2);
    bad_start(1, 2, 2, 0);
    bad_start(9, 2, 2, 2);
    bad_start(15, 1, 1, 1);

    // R12: req and start injected during movement are ignored
    do_start(0, 1, 4, 2, 1, 32'h1000, 32'h2000, 32'd8);
    run_req(4, 1'b0, 1'b1, "R12");
    begin
      int idle_beats = 0;
      repeat (5) begin @(negedge clk); if (rd_o) idle_beats++; end
      chk(idle_beats == 0, "R12", idle_beats, 0);
    end
    run_req(4, 1'b1, 1'b0, "R12");
    chk(status_o == 5'b00111, "R9", status_o, 5'b00111);
    @(negedge clk); clr_i = 5'h1F;
    @(negedge clk); clr_i = '0;

    // directed corners: all-ones counts, link-list mode
    run_trn(0, 1, 1, 1, 1);
    run_trn(3, 7, 1, 1, 1);
    run_trn(1, 2, 3, 1, 2);
    run_trn(2, 4, 2, 3, 2);

    for (int k = 0; k < 40; k++)
      run_trn($urandom_range(0, 3), $urandom_range(0, 8),
              $urandom_range(1, 3), $urandom_range(1, 3), $urandom_range(1, 3));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule